// File: doc/BRIEF.md
# GPI Edge Interrupt and Event Unit

This block watches a set of general-purpose input lines, split into bank A (six lines) and bank B (five lines). Each line first passes a debounce filter. A line's live level is kept in a status register. A scanner reacts to any debounced change. On each line a change can either set a sticky per-line interrupt bit on a chosen edge, or produce an encoded event record for a downstream FIFO.

The scanner does nothing until a debounced level differs from the level it last recorded. It then samples every line in a single clock and returns to idle straight away. Because there is no scan interval, both edges of a pulse are caught as long as the pulse outlasts the debounce filter. A host reaches the registers through a plain port with an address, a write strobe, a read strobe and 8-bit data. Reads are combinational. Side effects of a read take place at the clock edge on which the read strobe is high. Event records leave through a valid/ready handshake.

Top module: `gpi_irq_event_unit`

## Requirements
- R1: A raw level change is accepted only once the raw input has held the new value for DEB_CYCLES consecutive clocks. A glitch shorter than that changes neither the status nor the interrupt bits, and produces no event.
- R2: Address 3 (bank A, bits 5:0) and address 4 (bank B, bits 4:0) return the debounced level of each line. A line's status bit updates only when its input-enable bit is set. Input enables live at address 5 (A) and address 6 (B).
- R3: Each line has a polarity bit, at address 7 (A) or 8 (B). A value of 1 selects the rising edge and 0 selects the falling edge. The other edge never sets the line's interrupt bit.
- R4: A line sets its sticky interrupt bit when its interrupt enable (address 9 for A, 10 for B) is set and the selected edge occurs. The interrupt bits are at address 1 (A) and 2 (B). Any newly set bit also sets the master GPI flag, which is bit 1 of address 0 and drives output gpi_irq.
- R5: Reading address 1 or 2 clears that bank's interrupt bits after the value has been returned.
- R6: Writing 1 to bit 1 of address 0 clears the master GPI flag. Writing 1 to bit 0 clears the event flag. Writing 0 has no effect. If a new set and a clear happen in the same clock, the set wins.
- R7: A line with its event enable set never sets its interrupt bit. Event enables are at address 11 (A) and 12 (B). Each transition of such a line queues an event record and sets the event flag, which is bit 0 of address 0 and drives output event_irq.
- R8: An event record holds the new line level in bit 7 (1 = active) and an identifier of 36+n in bits 6:0 for line n. Lines 1 to 6 are bank A bits 0 to 5, and lines 7 to 11 are bank B bits 0 to 4. For example, line 2 rising gives 0xA6 and line 7 falling gives 0x2B.
- R9: Records from lines that change in the same scan are presented in ascending line order, one per accepted handshake. ev_data stays stable while ev_valid is high and ev_ready is low.
- R10: The scanner is idle until a debounced change occurs and returns to idle right after sampling. A pulse longer than the debounce filter therefore produces records for both of its edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpi_raw | input | NA+NB | Raw line levels, bank A in the low bits |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| gpi_irq | output | 1 | Master GPI interrupt flag |
| event_irq | output | 1 | Event interrupt flag |
| ev_valid | output | 1 | Event record available |
| ev_ready | input | 1 | Downstream FIFO accepts the record |
| ev_data | output | 8 | Event record: level in bit 7, identifier in bits 6:0 |

## Verification
The ordering and hold properties assume that ev_ready may fall at any time and that the host never retargets a line's enables while its records are still pending. The bench changes configuration only when the output is empty, and it drives a ready pattern that stalls one cycle in every three. The remaining properties take inputs only from the debounced side, so any raw waveform is legal. The stimulus covers glitches shorter than the filter, single-line edges, simultaneous edges on several lines, and a short pulse.

// File: rtl/gpi_irq_event_unit.sv
module gpi_irq_event_unit #(
  parameter int NA         = 6,
  parameter int NB         = 5,
  parameter int DEB_CYCLES = 7000,
  parameter int ID_BASE    = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NA+NB-1:0] gpi_raw,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             gpi_irq,
  output logic             event_irq,
  output logic             ev_valid,
  input  logic             ev_ready,
  output logic [7:0]       ev_data
);
  localparam int N  = NA + NB;
  localparam int CW = $clog2(DEB_CYCLES + 1);
  localparam int SW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] deb, seen, status, inp_en, level, int_en, evt_en, istat, pend, snap;

  for (genvar g = 0; g < N; g++) begin : g_deb
    logic [CW-1:0] cnt;
    logic          d_q;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt <= '0;
        d_q <= 1'b0;
      end else if (gpi_raw[g] == d_q) begin
        cnt <= '0;
      end else if (cnt == CW'(DEB_CYCLES - 1)) begin
        cnt <= '0;
        d_q <= gpi_raw[g];
      end else begin
        cnt <= cnt + 1'b1;
      end
    assign deb[g] = d_q;
  end

  wire [N-1:0] chg  = deb ^ seen;
  wire         scan = (|chg) && !(|pend);
  wire [N-1:0] upd  = chg & inp_en;
  wire [N-1:0] hit  = (upd & deb & level) | (upd & ~deb & ~level);
  wire [N-1:0] irq_set = scan ? (hit & int_en & ~evt_en) : '0;
  wire [N-1:0] ev_set  = scan ? (upd & evt_en) : '0;

  logic [SW-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) sel = SW'(i);
  end

  assign ev_valid = |pend;
  assign ev_data  = {snap[sel], 7'(ID_BASE) + 7'(sel)};

  wire wr0  = reg_wr && reg_addr == 4'd0;
  wire [N-1:0] clr = {{NB{reg_rd && reg_addr == 4'd2}}, {NA{reg_rd && reg_addr == 4'd1}}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      seen <= '0; status <= '0; istat <= '0; pend <= '0; snap <= '0;
      gpi_irq <= 1'b0; event_irq <= 1'b0;
    end else begin
      if (scan) begin
        seen   <= deb;
        snap   <= deb;
        pend   <= ev_set;
        status <= (status & ~inp_en) | (deb & inp_en);
      end else if (ev_valid && ev_ready) begin
        pend[sel] <= 1'b0;
      end
      istat <= (istat & ~clr) | irq_set;
      if (|irq_set) gpi_irq <= 1'b1;
      else if (wr0 && reg_wdata[1]) gpi_irq <= 1'b0;
      if (|ev_set) event_irq <= 1'b1;
      else if (wr0 && reg_wdata[0]) event_irq <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      inp_en <= '0; level <= '0; int_en <= '0; evt_en <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        4'd5:  inp_en[NA-1:0] <= reg_wdata[NA-1:0];
        4'd6:  inp_en[N-1:NA] <= reg_wdata[NB-1:0];
        4'd7:  level[NA-1:0]  <= reg_wdata[NA-1:0];
        4'd8:  level[N-1:NA]  <= reg_wdata[NB-1:0];
        4'd9:  int_en[NA-1:0] <= reg_wdata[NA-1:0];
        4'd10: int_en[N-1:NA] <= reg_wdata[NB-1:0];
        4'd11: evt_en[NA-1:0] <= reg_wdata[NA-1:0];
        4'd12: evt_en[N-1:NA] <= reg_wdata[NB-1:0];
        default: ;
      endcase
    end

  function automatic logic [7:0] pa(input logic [N-1:0] v);
    return 8'(v[NA-1:0]);
  endfunction
  function automatic logic [7:0] pb(input logic [N-1:0] v);
    return 8'(v[N-1:NA]);
  endfunction

  always_comb
    case (reg_addr)
      4'd0:    reg_rdata = {6'b0, gpi_irq, event_irq};
      4'd1:    reg_rdata = pa(istat);
      4'd2:    reg_rdata = pb(istat);
      4'd3:    reg_rdata = pa(status);
      4'd4:    reg_rdata = pb(status);
      4'd5:    reg_rdata = pa(inp_en);
      4'd6:    reg_rdata = pb(inp_en);
      4'd7:    reg_rdata = pa(level);
      4'd8:    reg_rdata = pb(level);
      4'd9:    reg_rdata = pa(int_en);
      4'd10:   reg_rdata = pb(int_en);
      4'd11:   reg_rdata = pa(evt_en);
      4'd12:   reg_rdata = pb(evt_en);
      default: reg_rdata = 8'h00;
    endcase

  p_status_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status ^ $past(status)) & ~$past(inp_en)) == '0);

  p_master_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (istat & ~$past(istat)) != '0 |-> gpi_irq);

  p_evt_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (istat & ~$past(istat) & $past(evt_en)) == '0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_data));

  p_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_valid || ev_data[6:0] > $past(ev_data[6:0]));
endmodule

// File: tb/gpi_irq_event_unit_tb_top.sv
module gpi_irq_event_unit_tb_top;
  localparam int NA = 6, NB = 5, N = NA + NB, DEB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] gpi_raw = '0;
  logic [3:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0, ev_ready = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata, ev_data;
  logic gpi_irq, event_irq, ev_valid;
  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  gpi_irq_event_unit #(.NA(NA), .NB(NB), .DEB_CYCLES(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .gpi_raw(gpi_raw), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .gpi_irq(gpi_irq), .event_irq(event_irq),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1 reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(posedge clk); #1 reg_addr = a; reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(posedge clk); #1 reg_rd = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic [N-1:0] mask, input logic lvl);
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) if (mask[i]) gpi_raw[i] = lvl;
  endtask

  task automatic expect_ev(input logic [7:0] rec);
    exp_q.push_back(rec);
  endtask

  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      ev_ready = (k % 3) != 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && ev_valid && ev_ready) begin
      if (exp_q.size() == 0) check("R9 unexpected record", ev_data, 8'hxx);
      else check("R8/R9 record", ev_data, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    settle(5);
    rst_n = 1'b1;
    settle(2);
    rd(4'd0, v); check("R6 reset master", v, 8'h00);
    check("R9 reset valid", {7'b0, ev_valid}, 8'h00);
    rd(4'd3, v); check("R2 reset status", v, 8'h00);

    wr(4'd5, 8'h3F); wr(4'd6, 8'h1B);
    wr(4'd7, 8'h08); wr(4'd9, 8'h18);

    drive(11'h008, 1'b1); settle(20);
    rd(4'd3, v); check("R2 status line4", v, 8'h08);
    check("R4 gpi_irq", {7'b0, gpi_irq}, 8'h01);
    rd(4'd1, v); check("R4 istat rise", v, 8'h08);
    rd(4'd1, v); check("R5 clear on read", v, 8'h00);
    rd(4'd0, v); check("R4 master bit1", v, 8'h02);
    wr(4'd0, 8'h00); rd(4'd0, v); check("R6 write 0 keeps", v, 8'h02);
    wr(4'd0, 8'h02); check("R6 w1c gpi", {7'b0, gpi_irq}, 8'h00);

    drive(11'h008, 1'b0); settle(20);
    rd(4'd1, v); check("R3 falling ignored", v, 8'h00);
    rd(4'd3, v); check("R2 status low", v, 8'h00);

    drive(11'h010, 1'b1); settle(20);
    rd(4'd1, v); check("R3 rise ignored falling line", v, 8'h00);
    drive(11'h010, 1'b0); settle(20);
    rd(4'd1, v); check("R3 falling line5", v, 8'h10);
    wr(4'd0, 8'h02);

    drive(11'h008, 1'b1); settle(DEB / 2); drive(11'h008, 1'b0); settle(20);
    rd(4'd3, v); check("R1 glitch status", v, 8'h00);
    rd(4'd1, v); check("R1 glitch istat", v, 8'h00);

    drive(11'h100, 1'b1); settle(20);
    rd(4'd4, v); check("R2 disabled line", v, 8'h00);
    drive(11'h100, 1'b0); settle(20);

    wr(4'd11, 8'h0A); wr(4'd12, 8'h01);
    expect_ev(8'hAB); drive(11'h040, 1'b1); settle(20);
    expect_ev(8'hA8); drive(11'h008, 1'b1); settle(20);
    expect_ev(8'hA6); drive(11'h002, 1'b1); settle(20);
    rd(4'd1, v); check("R7 no istat on event line", v, 8'h00);
    check("R7 gpi_irq quiet", {7'b0, gpi_irq}, 8'h00);
    rd(4'd0, v); check("R7 event flag", v, 8'h01);
    wr(4'd0, 8'h01); check("R6 w1c event", {7'b0, event_irq}, 8'h00);
    rd(4'd3, v); check("R2 status events", v, 8'h0A);

    expect_ev(8'h26); expect_ev(8'h28); expect_ev(8'h2B);
    drive(11'h04A, 1'b0); settle(30);
    check("R9 burst drained", 8'(exp_q.size()), 8'h00);

    expect_ev(8'hA6); expect_ev(8'h26);
    drive(11'h002, 1'b1); settle(DEB + 4); drive(11'h002, 1'b0); settle(40);
    check("R10 pulse both edges", 8'(exp_q.size()), 8'h00);
    check("R10 scanner idle", {7'b0, ev_valid}, 8'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule